// File: doc/BRIEF.md
# Register Scoreboard RAW Stall Unit

This unit guards an in-order pipeline with 32 architectural registers against read-after-write hazards. No results are forwarded. Each register has one pending bit. The bit is set when a producing instruction leaves the decode stage. It is cleared when that instruction's result is written back.

While an instruction sits in decode, its used source registers are compared against these bits. If any used source is still pending, decode is held by a combinational stall output. The held instruction retries each cycle until every one of its sources is valid.

A write-back in the current cycle counts as valid for the decode check in that same cycle. Register 0 is hard-wired to zero, so it is never tracked.

Top module: `reg_scoreboard`

## Requirements
- R1: After reset, all 32 pending bits are clear, so no source register causes a stall.
- R2: With `dec_valid_i` high, `stall_o` is high in the same cycle when a used source names a nonzero register whose pending bit is set.
- R3: `stall_o` is low whenever `dec_valid_i` is low.
- R4: A source whose use flag is low never causes a stall, whatever its index.
- R5: Register 0 never causes a stall, and an instruction writing register 0 marks nothing pending.
- R6: A destination is marked pending only in a cycle where `dec_valid_i` and `rd_wr_i` are high and `stall_o` is low. A stalled instruction marks nothing.
- R7: A write-back (`wb_valid_i` with `wb_idx_i`) clears that register's pending bit from the next cycle on.
- R8: A write-back to a register in the same cycle that decode checks it makes the check see the register as valid.
- R9: When one register is both newly marked pending and written back in the same cycle, it ends up pending.
- R10: An unstalled decode with `rd_wr_i` low marks no register pending.
- R11: Both source ports are checked, and a pending register on either port alone raises `stall_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dec_valid_i | input | 1 | An instruction is present in decode |
| rs1_idx_i | input | 5 | First source register index |
| rs1_use_i | input | 1 | First source is read |
| rs2_idx_i | input | 5 | Second source register index |
| rs2_use_i | input | 1 | Second source is read |
| rd_idx_i | input | 5 | Destination register index |
| rd_wr_i | input | 1 | Instruction writes its destination |
| wb_valid_i | input | 1 | Write-back commits this cycle |
| wb_idx_i | input | 5 | Register being written back |
| stall_o | output | 1 | Hold the decode stage this cycle |

## Verification
The bench targets the moments where the pending bit and the check can disagree. The first is a same-cycle write-back. A design without the bypass would stall one extra cycle. The second is a simultaneous set and clear of one register. Letting the clear win would let a later reader past an unfinished producer. The third is a stalled instruction. A design that marks its destination anyway would block readers of a register that nobody will ever write. Register 0, an unused source and a non-writing instruction are also probed, because each must leave the bits untouched and the stall low.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int unsigned NUM_REGS = 32;
  localparam int unsigned IDX_W    = $clog2(NUM_REGS);
  localparam int unsigned NUM_SRC  = 2;

  typedef logic [IDX_W-1:0]    reg_idx_t;
  typedef logic [NUM_REGS-1:0] reg_vec_t;
endpackage

// File: rtl/sb_pending_bits.sv
module sb_pending_bits #(
  parameter int unsigned NREGS = 32,
  localparam int unsigned IW   = $clog2(NREGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_en_i,
  input  logic [IW-1:0]    set_idx_i,
  input  logic             clr_en_i,
  input  logic [IW-1:0]    clr_idx_i,
  output logic [NREGS-1:0] pend_o
);
  logic [NREGS-1:0] pend_q;

  for (genvar g = 0; g < NREGS; g++) begin : g_bit
    logic set_hit, clr_hit;
    assign set_hit = set_en_i && (set_idx_i == IW'(g));
    assign clr_hit = clr_en_i && (clr_idx_i == IW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      pend_q[g] <= 1'b0;
      else if (set_hit) pend_q[g] <= 1'b1;  // set wins over same-cycle clear
      else if (clr_hit) pend_q[g] <= 1'b0;
    end
  end

  assign pend_o = pend_q;

  a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_i |=> pend_q[$past(set_idx_i)]);
  a_r7_wb_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && !(set_en_i && set_idx_i == clr_idx_i)) |=> !pend_q[$past(clr_idx_i)]);
endmodule

// File: rtl/sb_src_check.sv
module sb_src_check #(
  parameter int unsigned NREGS = 32,
  localparam int unsigned IW   = $clog2(NREGS)
) (
  input  logic             use_i,
  input  logic [IW-1:0]    idx_i,
  input  logic [NREGS-1:0] pend_i,
  input  logic             wb_valid_i,
  input  logic [IW-1:0]    wb_idx_i,
  output logic             hit_o
);
  logic nonzero, bypass;
  assign nonzero = (idx_i != '0);
  assign bypass  = wb_valid_i && (wb_idx_i == idx_i);
  assign hit_o   = use_i && nonzero && pend_i[idx_i] && !bypass;
endmodule

// File: rtl/reg_scoreboard.sv
module reg_scoreboard
  import sb_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     dec_valid_i,
  input  reg_idx_t rs1_idx_i,
  input  logic     rs1_use_i,
  input  reg_idx_t rs2_idx_i,
  input  logic     rs2_use_i,
  input  reg_idx_t rd_idx_i,
  input  logic     rd_wr_i,
  input  logic     wb_valid_i,
  input  reg_idx_t wb_idx_i,
  output logic     stall_o
);
  reg_vec_t             pend;
  reg_idx_t             src_idx [NUM_SRC];
  logic [NUM_SRC-1:0]   src_use;
  logic [NUM_SRC-1:0]   src_hit;
  logic                 issue, mark_en;

  assign src_idx[0] = rs1_idx_i;
  assign src_idx[1] = rs2_idx_i;
  assign src_use    = {rs2_use_i, rs1_use_i};

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    sb_src_check #(.NREGS(NUM_REGS)) u_chk (
      .use_i     (src_use[s]),
      .idx_i     (src_idx[s]),
      .pend_i    (pend),
      .wb_valid_i(wb_valid_i),
      .wb_idx_i  (wb_idx_i),
      .hit_o     (src_hit[s])
    );
  end

  assign stall_o = dec_valid_i && (|src_hit);
  assign issue   = dec_valid_i && !stall_o;
  assign mark_en = issue && rd_wr_i && (rd_idx_i != '0);

  sb_pending_bits #(.NREGS(NUM_REGS)) u_bits (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_en_i (mark_en),
    .set_idx_i(rd_idx_i),
    .clr_en_i (wb_valid_i),
    .clr_idx_i(wb_idx_i),
    .pend_o   (pend)
  );

  a_r3_idle_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> dec_valid_i);
  a_r5_zero_never_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend[0]);
  a_r6_stall_no_mark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !wb_valid_i) |=> pend == $past(pend));
  a_r10_no_write_no_mark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_wr_i && !wb_valid_i) |=> pend == $past(pend));
endmodule

// File: tb/tb_reg_scoreboard.sv
module tb_reg_scoreboard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dec_valid, rs1_use, rs2_use, rd_wr, wb_valid;
  logic [4:0] rs1_idx, rs2_idx, rd_idx, wb_idx;
  logic       stall;
  int         n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  reg_scoreboard dut (
    .clk_i(clk), .rst_ni(rst_n), .dec_valid_i(dec_valid),
    .rs1_idx_i(rs1_idx), .rs1_use_i(rs1_use),
    .rs2_idx_i(rs2_idx), .rs2_use_i(rs2_use),
    .rd_idx_i(rd_idx), .rd_wr_i(rd_wr),
    .wb_valid_i(wb_valid), .wb_idx_i(wb_idx), .stall_o(stall)
  );

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic idle();
    dec_valid = 0; rs1_use = 0; rs2_use = 0; rd_wr = 0; wb_valid = 0;
    rs1_idx = 0; rs2_idx = 0; rd_idx = 0; wb_idx = 0;
  endtask

  task automatic chk(input string req, input logic exp);
    n_chk++;
    if (stall !== exp) begin
      n_fail++;
      $display("FAIL %s: stall actual=%b expected=%b", req, stall, exp);
    end
  endtask

  // drive after negedge, settle, check, then commit at posedge
  task automatic cycle_begin();
    @(negedge clk); idle();
  endtask

  task automatic issue(input logic [4:0] rd, input logic wr);
    cycle_begin(); dec_valid = 1; rd_idx = rd; rd_wr = wr;
    @(posedge clk);
  endtask

  task automatic wb(input logic [4:0] r);
    cycle_begin(); wb_valid = 1; wb_idx = r;
    @(posedge clk);
  endtask

  task automatic probe(input string req, input logic [4:0] r, input logic exp);
    cycle_begin(); dec_valid = 1; rs1_use = 1; rs1_idx = r;
    #1 chk(req, exp);
    @(posedge clk);
  endtask

  task automatic t_reset();
    for (int r = 1; r < 32; r += 10) probe("R1", 5'(r), 0);
  endtask

  task automatic t_basic();
    issue(5, 1);
    probe("R2", 5, 1);
    cycle_begin(); rs1_use = 1; rs1_idx = 5; #1 chk("R3", 0); @(posedge clk);
    cycle_begin(); dec_valid = 1; rs1_idx = 5; rs2_idx = 5; #1 chk("R4", 0); @(posedge clk);
    cycle_begin(); dec_valid = 1; rs2_use = 1; rs2_idx = 5; rs1_use = 1; rs1_idx = 3;
    #1 chk("R11", 1); @(posedge clk);
  endtask

  task automatic t_zero_nowrite();
    issue(0, 1);
    probe("R5", 0, 0);
    issue(7, 0);
    probe("R10", 7, 0);
  endtask

  task automatic t_stalled_no_mark();
    cycle_begin(); dec_valid = 1; rs1_use = 1; rs1_idx = 5; rd_idx = 9; rd_wr = 1;
    #1 chk("R6 stalled", 1); @(posedge clk);
    probe("R6", 9, 0);
  endtask

  task automatic t_bypass_clear();
    cycle_begin(); dec_valid = 1; rs1_use = 1; rs1_idx = 5; wb_valid = 1; wb_idx = 5;
    #1 chk("R8", 0); @(posedge clk);
    probe("R7", 5, 0);
  endtask

  task automatic t_set_wins();
    issue(12, 1);
    cycle_begin(); dec_valid = 1; rd_idx = 12; rd_wr = 1; wb_valid = 1; wb_idx = 12;
    @(posedge clk);
    probe("R9", 12, 1);
    wb(12);
    probe("R7", 12, 0);
  endtask

  initial begin
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_basic();
    t_zero_nowrite();
    t_stalled_no_mark();
    t_bypass_clear();
    t_set_wins();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule